// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the lookup half of a cache for 32-bit byte addresses. It keeps one tag, one valid flag and one usage flag for each of 1024 lines of 64 bytes. The lines form 64 sets of 16 ways. Every request address is cut into a line offset, a set index and a tag. The tag is compared against every valid way of the indexed set. The response reports a hit and the way that holds the line.

On a miss the block picks a victim way in the same set and writes the new tag into it, so the line is resident from then on. Victim choice uses one usage flag per line instead of a full age order. Data storage, the memory side and write-back belong to the blocks around this directory. A flush input drops every line at once.

A request is taken on the clock edge where `req_valid` is high. The result appears on the registered response outputs in the following cycle. All state updates of that request are already done by that edge, so the next request sees them.

Top module: `cache_tag_dir`

## Requirements
- R1: The address is split as offset = bits [5:0], set index = bits [11:6] and tag = bits [31:12]. Addresses that differ only in the offset reach the same line. The same tag under a different index is a separate line.
- R2: Each request taken at a clock edge gives `rsp_valid` high for exactly the next cycle. `rsp_valid` is low in any cycle that follows an edge without a request.
- R3: A request hits (`rsp_hit` = 1) when a valid way of the indexed set holds an equal tag. `rsp_way` then gives that way number.
- R4: On a miss, `rsp_hit` = 0 and `rsp_way` gives the victim way. In the same edge the victim's tag is written and its valid flag is set, so a repeat of the address hits in that way.
- R5: When the set has one or more invalid ways, the victim is the invalid way with the lowest number.
- R6: When all 16 ways of the set are valid, the victim is the lowest-numbered way whose usage flag is 0.
- R7: Every hit or fill sets the usage flag of the way it touched. If that leaves all 16 usage flags of the set at 1, every flag in the set except the touched one is cleared.
- R8: A cycle with `flush` high clears the valid and usage flags of every line. Flush takes precedence over a request in the same cycle: that request gets no response and installs nothing.
- R9: Synchronous active-high `rst` marks every line invalid, clears every usage flag and drives `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | 1 = tag found, 0 = miss, and the line was installed |
| rsp_way | output | 4 | Way that hit, or way filled on a miss |

## Verification
The bench fills one set completely and then drives the usage flags into the all-ones case. A design that forgets the clearing step, or that also clears the flag it just set, then sends a later miss to the wrong way. Repeat accesses that differ only in their offset, and equal tags placed in two sets, expose a wrong address split: either a spurious miss or a false hit. A flush raised together with a request checks that nothing gets installed. A design that let the request through would hit on the repeat instead of missing. A reset in the middle of the run confirms that lines already resident are no longer found afterwards.

// File: rtl/cache_dir_pkg.sv
`timescale 1ns/1ps
package cache_dir_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFFSET_W = 6;
    localparam int INDEX_W  = 6;
    localparam int WAYS     = 16;
    localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;
    localparam int SETS     = 1 << INDEX_W;
    localparam int WAY_W    = $clog2(WAYS);

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [INDEX_W-1:0] idx_t;
    typedef logic [WAYS-1:0]    wmask_t;
    typedef logic [WAY_W-1:0]   way_t;

    typedef struct packed {
        tag_t                tag;
        idx_t                idx;
        logic [OFFSET_W-1:0] off;
    } addr_fields_t;

    typedef struct packed {
        logic hit;
        way_t way;
    } lookup_t;

    // lowest set bit of a way mask; 0 when the mask is empty
    function automatic way_t lowest_way(wmask_t m);
        way_t r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (m[i]) r = way_t'(i);
        end
        return r;
    endfunction

    function automatic wmask_t way_bit(way_t w);
        return wmask_t'(1) << w;
    endfunction

endpackage

// File: rtl/cdir_tag_match.sv
`timescale 1ns/1ps
module cdir_tag_match
    import cache_dir_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tag_t   way_tags [WAYS],
    input  wmask_t way_valid,
    input  tag_t   look_tag,
    output lookup_t result
);

    wmask_t match_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tags[w] == look_tag);
    end

    assign result.hit = |match_vec;
    assign result.way = lowest_way(match_vec);

    // R3
    multi_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: rtl/cdir_victim_pick.sv
`timescale 1ns/1ps
module cdir_victim_pick
    import cache_dir_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wmask_t way_valid,
    input  wmask_t way_usage,
    output way_t   victim
);

    wmask_t free_ways;
    wmask_t cold_ways;

    assign free_ways = ~way_valid;
    assign cold_ways = ~way_usage;

    always_comb begin
        if (|free_ways) victim = lowest_way(free_ways);
        else            victim = lowest_way(cold_ways);
    end

    // R5
    victim_free_chk: assert property (@(posedge clk) disable iff (rst)
        (|free_ways) |-> !way_valid[victim]);

    // R6
    victim_cold_chk: assert property (@(posedge clk) disable iff (rst)
        (&way_valid) |-> !way_usage[victim]);

endmodule

// File: rtl/cdir_usage_next.sv
`timescale 1ns/1ps
module cdir_usage_next
    import cache_dir_pkg::*;
(
    input  wmask_t cur_usage,
    input  way_t   touched,
    output wmask_t nxt_usage
);

    wmask_t marked;

    assign marked = cur_usage | way_bit(touched);

    always_comb begin
        if (&marked) nxt_usage = way_bit(touched);
        else         nxt_usage = marked;
    end

endmodule

// File: rtl/cache_tag_dir.sv
`timescale 1ns/1ps
module cache_tag_dir
    import cache_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way
);

    tag_t   tag_mem [SETS][WAYS];
    wmask_t valid_q [SETS];
    wmask_t usage_q [SETS];

    addr_fields_t fields;
    tag_t         set_tags [WAYS];
    wmask_t       set_valid;
    wmask_t       set_usage;
    wmask_t       usage_upd;
    lookup_t      look;
    way_t         victim;
    way_t         touched;
    idx_t         rsp_set_q;
    logic         take_req;
    logic         unused_offset;

    assign fields        = addr_fields_t'(req_addr);
    assign unused_offset = ^fields.off;
    assign set_valid     = valid_q[fields.idx];
    assign set_usage     = usage_q[fields.idx];
    assign take_req      = req_valid && !flush;

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_mem[fields.idx][w];
    end

    cdir_tag_match u_match (
        .clk       (clk),
        .rst       (rst),
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .look_tag  (fields.tag),
        .result    (look)
    );

    cdir_victim_pick u_victim (
        .clk       (clk),
        .rst       (rst),
        .way_valid (set_valid),
        .way_usage (set_usage),
        .victim    (victim)
    );

    assign touched = look.hit ? look.way : victim;

    cdir_usage_next u_usage (
        .cur_usage (set_usage),
        .touched   (touched),
        .nxt_usage (usage_upd)
    );

    // flag state and response registers
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                usage_q[s] <= '0;
            end
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_set_q <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= look.hit;
                rsp_way   <= touched;
                rsp_set_q <= fields.idx;
                usage_q[fields.idx] <= usage_upd;
                if (!look.hit) valid_q[fields.idx][victim] <= 1'b1;
            end
        end
    end

    // tag storage carries no reset; the valid flags qualify it
    always_ff @(posedge clk) begin
        if (!rst && take_req && !look.hit)
            tag_mem[fields.idx][victim] <= fields.tag;
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        take_req |=> rsp_valid);

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rsp_valid);

    // R4
    installed_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> valid_q[rsp_set_q][rsp_way]);

    // R7
    usage_marked_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (usage_q[rsp_set_q][rsp_way] && !(&usage_q[rsp_set_q])));

endmodule

// File: tb/sim_cache_tag_dir.sv
`timescale 1ns/1ps
module sim_cache_tag_dir;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [3:0]  rsp_way;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cache_tag_dir u0 (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_way   (rsp_way)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [3:0]  way;
    } vec_t;

    // tag A = 00001, tag B = 00002, tag C = ABCDE; set 5 unless noted
    localparam vec_t VECS [7] = '{
        '{32'h0000_1140, 1'b0, 4'd0},   // A off 0: miss, way 0
        '{32'h0000_117F, 1'b1, 4'd0},   // A off 3F: same line
        '{32'h0000_2140, 1'b0, 4'd1},   // B: miss, next free way
        '{32'h0000_1180, 1'b0, 4'd0},   // A in set 6: own line
        '{32'h0000_2140, 1'b1, 4'd1},   // B hit
        '{32'hABCD_E140, 1'b0, 4'd2},   // C miss
        '{32'h0000_1140, 1'b1, 4'd0}    // A hit
    };

    function automatic logic [31:0] mk(logic [19:0] tag, logic [5:0] idx);
        return {tag, idx, 6'd0};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(logic [31:0] addr, logic exp_hit, logic [3:0] exp_way, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {2'b00, rsp_valid, rsp_hit, rsp_way}, {2'b00, 1'b1, exp_hit, exp_way});
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset
        check("R9 reset rsp_valid", {7'd0, rsp_valid}, 8'd0);
        rst = 1'b0;

        // R1 R3 R4 R5 table walk
        for (int i = 0; i < 7; i++) begin
            access(VECS[i].addr, VECS[i].hit, VECS[i].way,
                   $sformatf("R1/R3/R4 table[%0d]", i));
        end

        // R2: no request, no response
        @(negedge clk);
        check("R2 idle rsp_valid", {7'd0, rsp_valid}, 8'd0);

        // R5: fill set 9 from empty, lowest invalid way first
        for (int w = 0; w < 16; w++)
            access(mk(20'h100 + 20'(w), 6'd9), 1'b0, 4'(w), "R5 fill");
        // usage now only way 15 (R7 clearing on the last fill)
        access(mk(20'h100, 6'd9), 1'b1, 4'd0,  "R3 hit way0");
        access(mk(20'h200, 6'd9), 1'b0, 4'd1,  "R6 victim way1");
        for (int w = 2; w < 15; w++)
            access(mk(20'h1FF + 20'(w), 6'd9), 1'b0, 4'(w), "R6 replace");
        // way 14 filled: all flags were set, all but way 14 cleared
        access(mk(20'h300, 6'd9), 1'b0, 4'd0,  "R7 clear keeps touched");
        access(mk(20'h10F, 6'd9), 1'b1, 4'd15, "R7 way15 resident");
        access(mk(20'h301, 6'd9), 1'b0, 4'd1,  "R6 next cold way");
        access(mk(20'h100, 6'd9), 1'b0, 4'd2,  "R4 evicted tag misses");
        access(mk(20'h100, 6'd9), 1'b1, 4'd2,  "R4 refill hits");

        // R8: flush alone
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R8 flush no rsp", {7'd0, rsp_valid}, 8'd0);
        access(mk(20'h10F, 6'd9), 1'b0, 4'd0, "R8 set9 emptied");
        access(32'h0000_1140,     1'b0, 4'd0, "R8 set5 emptied");

        // R8: flush with a request in the same cycle
        @(negedge clk);
        flush     = 1'b1;
        req_valid = 1'b1;
        req_addr  = mk(20'h777, 6'd12);
        @(negedge clk);
        flush     = 1'b0;
        req_valid = 1'b0;
        check("R8 flush beats req", {7'd0, rsp_valid}, 8'd0);
        access(mk(20'h777, 6'd12), 1'b0, 4'd0, "R8 nothing installed");
        access(mk(20'h777, 6'd12), 1'b1, 4'd0, "R4 now resident");

        // R9: reset mid-run drops resident lines
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", {7'd0, rsp_valid}, 8'd0);
        rst = 1'b0;
        access(mk(20'h777, 6'd12), 1'b0, 4'd0, "R9 line gone");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule